// File: doc/BRIEF.md
# PLL Divisor Search Engine

This block takes a requested clock frequency in kHz and searches for PLL settings that reach it from a fixed reference. The settings are a reference divider, a feedback multiplier, an output divider and, when asked for, an external post-divider. A pulse on `start_i` launches the search. The engine works out the output divider and the VCO frequency it targets. It then tries reference dividers one per iteration, picks the multiplier that comes nearest, and keeps the candidate with the smallest error.

Each division runs on a single shared radix-2 restoring divider that takes a fixed number of cycles. A full search can take several thousand cycles. When the search ends, the engine pulses `done_o` for one cycle and presents either a result or an error code. These outputs stay unchanged until the next start. Writing the values into PLL registers is left to the surrounding logic.

Top module: `pll_divisor_search`

## Requirements
- R1: A `start_i` pulse while idle begins a search. `busy_o` is high from the next cycle until the result appears. `done_o` is high for exactly one cycle. All result outputs hold their values from that cycle until the next start.
- R2: A requested frequency of 0 completes in the cycle after start with `err_o` = 1, and no division takes place.
- R3: The raw output divider is ceil(VCO_MIN / f), with VCO_MIN = 440000 kHz. With `ext_en_i` high, `ext_o` = ceil(raw / 16) and the divider becomes ceil(raw / `ext_o`); otherwise `ext_o` = 1. A divider above 1 is then rounded up to the next even number, and the value reported on `no_o` is this final divider.
- R4: The VCO target is f × output divider × external divider. If it lies outside 440000..2200000 kHz, or if the output divider exceeds 16, the search ends with `err_o` = 2.
- R5: Reference divider candidates nr go upward from 1 while nr < 64. The divided reference is floor(REF_KHZ / nr). The search stops once this value falls below 269 kHz, or once an error of zero has been recorded. The best error starts at the VCO target, and a candidate replaces it only when its error is strictly smaller.
- R6: For each candidate, the multiplier is floor(VCO / fref) and the error is the remainder. A candidate with a multiplier of 4096 or more is skipped. If the remainder exceeds floor(fref / 2) and the multiplier + 1 is below 4096, the multiplier is raised by one and the error becomes fref − remainder.
- R7: If the final best error exceeds 4000 kHz, the search ends with `err_o` = 3. A successful search reports `err_o` = 0.
- R8: On success, `miss_o` equals |VCO − `nf_o` × floor(REF_KHZ / `nr_o`)|, where VCO = f × `no_o` × `ext_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a search when the engine is idle |
| freq_khz_i | input | FW | Requested output frequency in kHz |
| ext_en_i | input | 1 | Allow the external post-divider |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 2 | 0 ok, 1 zero frequency, 2 no legal VCO, 3 error above ceiling |
| nr_o | output | 6 | Chosen reference divider |
| nf_o | output | 12 | Chosen feedback multiplier |
| no_o | output | 5 | Chosen output divider |
| ext_o | output | FW | Chosen external post-divider |
| miss_o | output | FW | Remaining frequency error in kHz |

## Verification
The error-ceiling failure is the hardest outcome to reach from the ports. With a 24 MHz reference, the candidate at nr = 6 alone already keeps the error at or below 4000 kHz, so no legal request can fail the ceiling. The bench therefore also drives a second instance whose reference is set to 300 kHz. On that instance every multiplier for a 1.5 GHz VCO is at least 4096, so every candidate is skipped and the best error stays at the VCO target. The rounding boundary, where the remainder equals exactly half of fref, is reached through requests such as 148500 kHz.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  localparam int SRCH_W = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_NO0, ST_NOEXT, ST_VCO, ST_FREF, ST_NF, ST_FINAL, ST_DONE
  } srch_state_t;

  typedef enum logic [1:0] {
    ERR_NONE  = 2'd0,
    ERR_ZERO  = 2'd1,
    ERR_RANGE = 2'd2,
    ERR_MISS  = 2'd3
  } srch_err_t;

  // ceiling of a quotient from the floor quotient and the remainder
  function automatic logic [SRCH_W-1:0] ceil_qr(input logic [SRCH_W-1:0] q,
                                                input logic [SRCH_W-1:0] r);
    return q + ((r != '0) ? SRCH_W'(1) : SRCH_W'(0));
  endfunction

  // dividers above one are forced to the next even value
  function automatic logic [SRCH_W-1:0] even_up(input logic [SRCH_W-1:0] x);
    return (x > SRCH_W'(1)) ? ((x + SRCH_W'(1)) & ~SRCH_W'(1)) : x;
  endfunction

  // external post-divider: ceiling of the raw divider over sixteen
  function automatic logic [SRCH_W-1:0] ext_from(input logic [SRCH_W-1:0] raw);
    return (raw + SRCH_W'(15)) >> 4;
  endfunction

endpackage

// File: rtl/pll_seq_divider.sv
module pll_seq_divider #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic          done_o,
  output logic [DW-1:0] quot_o,
  output logic [DW-1:0] rem_o
);
  localparam int CW = $clog2(DW + 1);

  logic [DW:0]   acc_q;
  logic [DW-1:0] quo_q, dvs_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;

  logic [DW:0] shifted;
  logic        fits;
  assign shifted = {acc_q[DW-1:0], quo_q[DW-1]};
  assign fits    = shifted >= {1'b0, dvs_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else if (go_i) begin
      acc_q  <= '0;
      quo_q  <= dividend_i;
      dvs_q  <= divisor_i;
      cnt_q  <= CW'(DW);
      run_q  <= 1'b1;
      done_o <= 1'b0;
    end else if (run_q) begin
      acc_q  <= fits ? (shifted - {1'b0, dvs_q}) : shifted;
      quo_q  <= {quo_q[DW-2:0], fits};
      cnt_q  <= cnt_q - CW'(1);
      run_q  <= (cnt_q != CW'(1));
      done_o <= (cnt_q == CW'(1));
    end else begin
      done_o <= 1'b0;
    end
  end

  assign quot_o = quo_q;
  assign rem_o  = acc_q[DW-1:0];

  // zero frequency is filtered before any division is issued
  assert_nonzero_divisor_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> (divisor_i != '0));

  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |-> !run_q);

endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval #(
  parameter int W        = 32,
  parameter int NF_LIMIT = 4096,
  localparam int NFW     = $clog2(NF_LIMIT)
) (
  input  logic [W-1:0]   quot_i,
  input  logic [W-1:0]   rem_i,
  input  logic [W-1:0]   fref_i,
  input  logic [W-1:0]   best_i,
  output logic           take_o,
  output logic [NFW-1:0] nf_o,
  output logic [W-1:0]   diff_o
);
  logic skip, bump;
  logic [W-1:0] nf_full;

  assign skip    = quot_i >= W'(NF_LIMIT);
  assign bump    = ((quot_i + W'(1)) < W'(NF_LIMIT)) && (rem_i > (fref_i >> 1));
  assign nf_full = bump ? (quot_i + W'(1)) : quot_i;
  assign diff_o  = bump ? (fref_i - rem_i) : rem_i;
  assign nf_o    = NFW'(nf_full);
  assign take_o  = !skip && (diff_o < best_i);

  always_comb begin
    if (take_o) assert_taken_fits_R6: assert (nf_full < W'(NF_LIMIT));
  end

endmodule

// File: rtl/pll_divisor_search.sv
module pll_divisor_search
  import pll_search_pkg::*;
#(
  parameter int REF_KHZ    = 24000,
  parameter int VCO_MIN    = 440000,
  parameter int VCO_MAX    = 2200000,
  parameter int FREF_MIN   = 269,
  parameter int NR_LIMIT   = 64,
  parameter int NF_LIMIT   = 4096,
  parameter int NO_LIMIT   = 16,
  parameter int MISS_LIMIT = 4000,
  localparam int FW  = SRCH_W,
  localparam int PW  = 2 * FW,
  localparam int NRW = $clog2(NR_LIMIT),
  localparam int NFW = $clog2(NF_LIMIT),
  localparam int NOW = $clog2(NO_LIMIT + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic [FW-1:0]  freq_khz_i,
  input  logic           ext_en_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [1:0]     err_o,
  output logic [NRW-1:0] nr_o,
  output logic [NFW-1:0] nf_o,
  output logic [NOW-1:0] no_o,
  output logic [FW-1:0]  ext_o,
  output logic [FW-1:0]  miss_o
);
  srch_state_t state_q;
  logic          wait_q, ext_en_q;
  logic [FW-1:0] f_q, no_q, ext_q, vco_q, best_q, fref_q;
  logic [NRW:0]  nr_q;
  logic [NRW-1:0] bnr_q;
  logic [NFW-1:0] bnf_q;

  logic [1:0]     res_err_q;
  logic [NRW-1:0] res_nr_q;
  logic [NFW-1:0] res_nf_q;
  logic [NOW-1:0] res_no_q;
  logic [FW-1:0]  res_ext_q, res_miss_q;

  // named internal events
  logic          div_go, div_done, loop_end, vco_bad, cand_take;
  logic [FW-1:0] dvd, dvs, quot, rem, no_even, cand_diff;
  logic [NFW-1:0] cand_nf;
  logic [PW-1:0] prod;

  assign loop_end = (best_q == '0) || (nr_q == (NRW+1)'(NR_LIMIT));
  assign no_even  = even_up(no_q);
  assign prod     = PW'(f_q) * PW'(no_even) * PW'(ext_q);
  assign vco_bad  = (no_even > FW'(NO_LIMIT)) || (prod < PW'(VCO_MIN)) ||
                    (prod > PW'(VCO_MAX));

  always_comb begin
    dvd    = '0;
    dvs    = '0;
    div_go = 1'b0;
    case (state_q)
      ST_NO0:   begin dvd = FW'(VCO_MIN); dvs = f_q;       div_go = !wait_q; end
      ST_NOEXT: begin dvd = no_q;         dvs = ext_q;     div_go = !wait_q; end
      ST_FREF:  begin dvd = FW'(REF_KHZ); dvs = FW'(nr_q); div_go = !wait_q && !loop_end; end
      ST_NF:    begin dvd = vco_q;        dvs = fref_q;    div_go = !wait_q; end
      default:  ;
    endcase
  end

  pll_seq_divider #(.DW(FW)) u_div (
    .clk(clk), .rst_n(rst_n), .go_i(div_go), .dividend_i(dvd), .divisor_i(dvs),
    .done_o(div_done), .quot_o(quot), .rem_o(rem)
  );

  pll_cand_eval #(.W(FW), .NF_LIMIT(NF_LIMIT)) u_eval (
    .quot_i(quot), .rem_i(rem), .fref_i(fref_q), .best_i(best_q),
    .take_o(cand_take), .nf_o(cand_nf), .diff_o(cand_diff)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  wait_q <= 1'b0;  ext_en_q <= 1'b0;
      f_q <= '0;  no_q <= '0;  ext_q <= '0;  vco_q <= '0;  best_q <= '0;
      fref_q <= '0;  nr_q <= '0;  bnr_q <= '0;  bnf_q <= '0;
      res_err_q <= ERR_NONE;  res_nr_q <= '0;  res_nf_q <= '0;
      res_no_q <= '0;  res_ext_q <= '0;  res_miss_q <= '0;
    end else begin
      if (div_go) wait_q <= 1'b1;
      if (div_done) wait_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          f_q      <= freq_khz_i;
          ext_en_q <= ext_en_i;
          if (freq_khz_i == '0) begin
            res_err_q <= ERR_ZERO;  res_nr_q <= '0;  res_nf_q <= '0;
            res_no_q <= '0;  res_ext_q <= '0;  res_miss_q <= '0;
            state_q <= ST_DONE;
          end else state_q <= ST_NO0;
        end
        ST_NO0: if (div_done) begin
          no_q <= ceil_qr(quot, rem);
          if (ext_en_q) begin
            ext_q   <= ext_from(ceil_qr(quot, rem));
            state_q <= ST_NOEXT;
          end else begin
            ext_q   <= FW'(1);
            state_q <= ST_VCO;
          end
        end
        ST_NOEXT: if (div_done) begin
          no_q    <= ceil_qr(quot, rem);
          state_q <= ST_VCO;
        end
        ST_VCO: if (vco_bad) begin
          res_err_q <= ERR_RANGE;  res_nr_q <= '0;  res_nf_q <= '0;
          res_no_q <= '0;  res_ext_q <= '0;  res_miss_q <= '0;
          state_q <= ST_DONE;
        end else begin
          no_q   <= no_even;
          vco_q  <= FW'(prod);
          best_q <= FW'(prod);
          nr_q   <= (NRW+1)'(1);
          bnr_q  <= '0;
          bnf_q  <= '0;
          state_q <= ST_FREF;
        end
        ST_FREF: begin
          if (!wait_q && loop_end) state_q <= ST_FINAL;
          else if (div_done) begin
            fref_q  <= quot;
            state_q <= (quot < FW'(FREF_MIN)) ? ST_FINAL : ST_NF;
          end
        end
        ST_NF: if (div_done) begin
          if (cand_take) begin
            best_q <= cand_diff;
            bnr_q  <= NRW'(nr_q);
            bnf_q  <= cand_nf;
          end
          nr_q    <= nr_q + (NRW+1)'(1);
          state_q <= ST_FREF;
        end
        ST_FINAL: begin
          res_err_q  <= (best_q > FW'(MISS_LIMIT)) ? ERR_MISS : ERR_NONE;
          res_nr_q   <= bnr_q;
          res_nf_q   <= bnf_q;
          res_no_q   <= NOW'(no_q);
          res_ext_q  <= ext_q;
          res_miss_q <= best_q;
          state_q    <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = (state_q == ST_DONE);
  assign busy_o = (state_q != ST_IDLE) && !done_o;
  assign err_o  = res_err_q;
  assign nr_o   = res_nr_q;
  assign nf_o   = res_nf_q;
  assign no_o   = res_no_q;
  assign ext_o  = res_ext_q;
  assign miss_o = res_miss_q;

  assert_done_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_hold_results_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !done_o) |-> $stable({err_o, nr_o, nf_o, no_o, ext_o, miss_o}));

  assert_zero_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i && freq_khz_i == '0) |=> (done_o && err_o == ERR_ZERO));

  assert_even_divider_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o == ERR_NONE) |-> (no_o == NOW'(1) || (!no_o[0] && no_o <= NOW'(NO_LIMIT))));

  assert_vco_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FREF) |-> (vco_q >= FW'(VCO_MIN) && vco_q <= FW'(VCO_MAX)));

  assert_best_shrinks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NF && $past(state_q == ST_NF)) |-> (best_q <= $past(best_q)));

  assert_nr_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o == ERR_NONE) |-> (nr_o != '0));

  assert_miss_ceiling_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o == ERR_NONE) |-> (miss_o <= FW'(MISS_LIMIT)));

endmodule

// File: tb/pll_divisor_search_tb.sv
module pll_divisor_search_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        start_a, start_b, ext_en;
  logic [31:0] freq;
  logic        busy_a, done_a, busy_b, done_b;
  logic [1:0]  err_a, err_b;
  logic [5:0]  nr_a, nr_b;
  logic [11:0] nf_a, nf_b;
  logic [4:0]  no_a, no_b;
  logic [31:0] ext_a, ext_b, miss_a, miss_b;

  pll_divisor_search u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_a), .freq_khz_i(freq), .ext_en_i(ext_en),
    .busy_o(busy_a), .done_o(done_a), .err_o(err_a), .nr_o(nr_a), .nf_o(nf_a),
    .no_o(no_a), .ext_o(ext_a), .miss_o(miss_a));

  pll_divisor_search #(.REF_KHZ(300)) u_dut_lowref (
    .clk(clk), .rst_n(rst_n), .start_i(start_b), .freq_khz_i(freq), .ext_en_i(ext_en),
    .busy_o(busy_b), .done_o(done_b), .err_o(err_b), .nr_o(nr_b), .nf_o(nf_b),
    .no_o(no_b), .ext_o(ext_b), .miss_o(miss_b));

  int checks = 0;
  int fails  = 0;
  bit hung   = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural restatement of the search
  task automatic model(input longint f, input bit ex, input longint rf,
                       output int e, output longint mnr, output longint mnf,
                       output longint mno, output longint mxd, output longint mdf);
    longint raw, vco, best;
    mnr = 0; mnf = 0; mno = 0; mxd = 0; mdf = 0;
    if (f == 0) begin e = 1; return; end
    raw = (440000 + f - 1) / f;
    if (ex) begin mxd = (raw + 15) / 16; mno = (raw + mxd - 1) / mxd; end
    else begin mxd = 1; mno = raw; end
    if (mno > 1 && (mno % 2) != 0) mno++;
    vco = f * mno * mxd;
    if (vco < 440000 || vco > 2200000 || mno > 16) begin e = 2; return; end
    best = vco;
    for (longint r = 1; r < 64 && best != 0; r++) begin
      longint fr, n, d;
      fr = rf / r;
      if (fr < 269) break;
      n = vco / fr;
      if (n >= 4096) continue;
      d = vco - n * fr;
      if (n + 1 < 4096 && d > fr / 2) begin n++; d = fr - d; end
      if (d < best) begin best = d; mnr = r; mnf = n; end
    end
    mdf = best;
    e = (best > 4000) ? 3 : 0;
  endtask

  task automatic run(input bit low, input longint f, input bit ex);
    int e; longint mnr, mnf, mno, mxd, mdf, rf;
    int waited;
    logic [1:0] s_err; logic [5:0] s_nr; logic [11:0] s_nf; logic [4:0] s_no;
    logic [31:0] s_ext, s_miss;
    rf = low ? 300 : 24000;
    model(f, ex, rf, e, mnr, mnf, mno, mxd, mdf);
    @(negedge clk);
    freq = 32'(f); ext_en = ex;
    if (low) start_b = 1'b1; else start_a = 1'b1;
    @(negedge clk);
    start_a = 1'b0; start_b = 1'b0;
    waited = 0;
    while (!(low ? done_b : done_a)) begin
      check(low ? busy_b : busy_a, "R1 busy during search", 0, 1);
      @(negedge clk);
      waited++;
      if (waited > 20000) begin
        hung = 1;
        check(0, "R1 watchdog", waited, 0);
        return;
      end
    end
    s_err  = low ? err_b  : err_a;   s_nr  = low ? nr_b  : nr_a;
    s_nf   = low ? nf_b   : nf_a;    s_no  = low ? no_b  : no_a;
    s_ext  = low ? ext_b  : ext_a;   s_miss = low ? miss_b : miss_a;
    if (e == 1)      check(s_err == 2'(e), "R2 zero request error code", s_err, e);
    else if (e == 2) check(s_err == 2'(e), "R4 vco range error code", s_err, e);
    else if (e == 3) check(s_err == 2'(e), "R7 error ceiling code", s_err, e);
    else begin
      check(s_err == 2'd0, "R7 success code", s_err, 0);
      check(longint'(s_no) == mno,  "R3 output divider", s_no, mno);
      check(longint'(s_ext) == mxd, "R3 external divider", s_ext, mxd);
      check(longint'(s_nr) == mnr,  "R5 reference divider", s_nr, mnr);
      check(longint'(s_nf) == mnf,  "R6 multiplier", s_nf, mnf);
      begin
        longint v, p, d;
        v = f * s_no * s_ext;
        p = longint'(s_nf) * (rf / (s_nr == 0 ? 1 : s_nr));
        d = (v > p) ? v - p : p - v;
        check(longint'(s_miss) == d && d == mdf, "R8 reported error", s_miss, mdf);
      end
    end
    if (e == 1) check(waited == 0, "R2 one cycle completion", waited, 0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(!(low ? done_b : done_a), "R1 done single pulse", 1, 0);
      check(!(low ? busy_b : busy_a), "R1 idle after done", 1, 0);
      check((low ? err_b : err_a) == s_err && (low ? nr_b : nr_a) == s_nr &&
            (low ? nf_b : nf_a) == s_nf && (low ? miss_b : miss_a) == s_miss,
            "R1 results held", 0, 1);
    end
  endtask

  initial begin
    start_a = 1'b0; start_b = 1'b0; ext_en = 1'b0; freq = '0;
    repeat (3) @(negedge clk);
    check(!busy_a && !done_a && err_a == 2'd0 && nr_a == '0, "R1 reset state", busy_a, 0);
    rst_n = 1'b1;
    run(0, 0, 0);          // R2
    run(0, 100000, 0);     // exact match, early exit R5
    run(0, 148500, 0);     // half-remainder boundary R6
    run(0, 1, 0);          // divider above sixteen R4
    run(0, 3000000, 0);    // vco above window R4
    run(0, 2200000, 0);    // upper edge of window R4
    run(0, 27500, 1);      // external divider R3
    run(0, 1, 1);          // largest external divider R3
    run(0, 450, 1);
    run(0, 65000, 1);
    run(0, 297000, 0);
    run(0, 12345, 1);
    run(0, 440000, 0);
    run(0, 0, 1);          // R2 with external enable
    run(1, 200000, 0);     // low reference, stop below minimum R5
    run(1, 500000, 0);
    run(1, 1500000, 0);    // every candidate skipped R7
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R1 global watchdog: actual %0d expected %0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule